// File: doc/BRIEF.md
# BCD Calendar Clock with Time-of-Day Alarm

This block keeps wall-clock time and a calendar in packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. It advances once per second. It supports a 12-hour mode with an afternoon flag and a 24-hour mode, and it lengthens February in leap years. A free-running enable input `tick_en` stands in for the oscillator. One second passes after `SUB_TICKS` of its pulses, counted by an internal phase counter.

A host interface block reaches the registers through a single-cycle read/write port. The read data is combinational on the address. A time-of-day alarm compares seconds, minutes, hours and day of week once per second. Bit 7 of each alarm register masks its field. A match raises a sticky request flag. The `irq` output is high while that flag and the alarm enable are both set. A stop bit in the control register freezes time, and it comes out of reset set.

Top module: `rtc_bcd_alarm`

## Requirements
- R1: After reset, control reads 0x80 (bit 7 stop = 1, bit 0 alarm enable = 0). Seconds, minutes, hours and year read 0x00. Day of week, date and month read 0x01. Status reads 0x00 and `irq` is 0.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 0xA alarm day, 0xB control, 0xC status (bit 0 = request flag, read-only). Every other address reads 0x00.
- R3: Bits with no function read 0 whatever is written. The kept bits are seconds/minutes 6:0, hours 6:0, day of week 2:0, date 5:0, month 4:0, year 7:0, alarm seconds/minutes/hours 7:0, alarm day 7 and 2:0, and control 7 and 0.
- R4: While the stop bit is 1, no time register changes except by host write. While it is 0, time advances one second on every `SUB_TICKS`-th `tick_en` pulse.
- R5: A write to seconds restarts the sub-second phase, so the next advance needs a full `SUB_TICKS` further pulses.
- R6: Seconds and minutes count BCD 00 to 59. Passing 59 returns the field to 00 and carries into the next field.
- R7: With hours bit 6 = 0 (24-hour), hours count 00 to 23, and 23 to 00 carries into the day.
- R8: With hours bit 6 = 1 (12-hour, bit 5 = PM, bits 4:0 = BCD 01 to 12), 11 goes to 12 and toggles PM, and 12 goes to 01 keeping PM. Going from 11 PM to 12 AM carries into the day.
- R9: A day carry moves the day of week 1 to 7 and wraps to 1. The date rolls to 01 after the last day of the month, carrying into the month. Month 12 rolls to 01, carrying into the year. Year 99 rolls to 00.
- R10: February has 29 days when the BCD year is divisible by 4 and 28 otherwise. April, June, September and November have 30 days, and the other months have 31.
- R11: Once per advanced second, the alarm compares the new time. Each of the four fields matches if its mask bit 7 is 1 or its value equals the time field. When all four match, the request flag is set.
- R12: Any read or write of addresses 7 to 0xA clears the request flag. A match in the same cycle wins. Reading status does not clear the flag.
- R13: `irq` is 1 exactly when the request flag and the control alarm-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Sub-second timebase pulse |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears alarm flag on alarm addresses) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Register read data, combinational on address |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The carry chain is driven from preset times just before each rollover. The cases are a plain second step, a minute carry, the full year-end cascade, the three 12-hour transitions, and month ends in a leap year, a common year and a 30-day month. Each case separates one boundary rule from its neighbours. Alarm tests start from the same pre-match time. They change only the mask pattern or one field, so the five matching rates and the mismatch case are each told apart. Partial-second pulse trains around a seconds write separate a restarted phase from a continuing one.

// File: rtl/rtc_pkg.sv
// Shared constants and BCD helpers for the calendar clock.
// Assumes packed BCD values held in 8-bit fields.
package rtc_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_SEC   = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_MIN   = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_HOUR  = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_DOW   = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_DATE  = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_MON   = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_YEAR  = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_ASEC  = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_AMIN  = 4'h8;
    localparam logic [ADDR_W-1:0] ADR_AHOUR = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_ADAY  = 4'hA;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'hB;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 4'hC;

    // Add one to a two-digit BCD value (caller handles the wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        else                return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // True when a BCD year is a multiple of four.
    function automatic logic bcd_leap(input logic [7:0] yr);
        if (yr[4]) return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
        else       return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    endfunction

    // Last date of a BCD month, in BCD.
    function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Sub-second phase counter: turns SUB_TICKS timebase pulses into one
// second step. Assumes SUB_TICKS >= 2. restart forces the phase to zero.
module rtc_prescaler #(
    parameter int SUB_TICKS = 4,
    parameter int PW        = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          run,
    input  logic          restart,
    output logic          sec_pulse,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(SUB_TICKS - 1);

    assign sec_pulse = tick_en && run && (phase == LAST) && !restart;

    // Advance the phase on each timebase pulse while running.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase <= '0;
        else if (restart)         phase <= '0;
        else if (tick_en && run)  phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/rtc_timekeeper.sv
// Time and calendar registers with the BCD carry chain.
// Assumes step is never high in a cycle with a host write to these registers.
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [7:0]        sec_q,
    output logic [7:0]        min_q,
    output logic [7:0]        hr_q,
    output logic [7:0]        dow_q,
    output logic [7:0]        date_q,
    output logic [7:0]        mon_q,
    output logic [7:0]        yr_q
);
    logic [7:0] nsec, nmin, nhr, ndow, ndate, nmon, nyr, inc8;
    logic       roll_min, roll_hr, roll_day, roll_mon, roll_yr;

    // Next-state of the whole calendar for one second step.
    always_comb begin
        nsec = sec_q;  nmin = min_q;  nhr = hr_q;  ndow = dow_q;
        ndate = date_q; nmon = mon_q; nyr = yr_q;  inc8 = 8'h00;
        roll_min = 1'b0; roll_hr = 1'b0; roll_day = 1'b0;
        roll_mon = 1'b0; roll_yr = 1'b0;
        if (step) begin
            if (sec_q == 8'h59) begin nsec = 8'h00; roll_min = 1'b1; end
            else nsec = bcd_inc(sec_q);
            if (roll_min) begin
                if (min_q == 8'h59) begin nmin = 8'h00; roll_hr = 1'b1; end
                else nmin = bcd_inc(min_q);
            end
            if (roll_hr) begin
                if (hr_q[6]) begin
                    if (hr_q[4:0] == 5'h12) nhr = {hr_q[7:5], 5'h01};
                    else if (hr_q[4:0] == 5'h11) begin
                        nhr      = {2'b01, ~hr_q[5], 5'h12};
                        roll_day = hr_q[5];
                    end else begin
                        inc8 = bcd_inc({3'b000, hr_q[4:0]});
                        nhr  = {hr_q[7:5], inc8[4:0]};
                    end
                end else begin
                    if (hr_q[5:0] == 6'h23) begin nhr = 8'h00; roll_day = 1'b1; end
                    else nhr = bcd_inc(hr_q);
                end
            end
            if (roll_day) begin
                ndow = (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
                if (date_q == last_date(mon_q, yr_q)) begin ndate = 8'h01; roll_mon = 1'b1; end
                else ndate = bcd_inc(date_q);
            end
            if (roll_mon) begin
                if (mon_q == 8'h12) begin nmon = 8'h01; roll_yr = 1'b1; end
                else nmon = bcd_inc(mon_q);
            end
            if (roll_yr) nyr = (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
        end
    end

    // Register update: host write (masked to kept bits) or carry chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00; dow_q <= 8'h01;
            date_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_SEC:  sec_q  <= wr_data & 8'h7F;
                ADR_MIN:  min_q  <= wr_data & 8'h7F;
                ADR_HOUR: hr_q   <= wr_data & 8'h7F;
                ADR_DOW:  dow_q  <= wr_data & 8'h07;
                ADR_DATE: date_q <= wr_data & 8'h3F;
                ADR_MON:  mon_q  <= wr_data & 8'h1F;
                ADR_YEAR: yr_q   <= wr_data;
                default:  ;
            endcase
        end else begin
            sec_q <= nsec; min_q <= nmin; hr_q <= nhr; dow_q <= ndow;
            date_q <= ndate; mon_q <= nmon; yr_q <= nyr;
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
// Time-of-day alarm registers, per-field masked match and request flag.
// Assumes check is high for one cycle after each advanced second.
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic              check,
    input  logic [7:0]        sec_q,
    input  logic [7:0]        min_q,
    input  logic [7:0]        hr_q,
    input  logic [7:0]        dow_q,
    output logic [7:0]        asec_q,
    output logic [7:0]        amin_q,
    output logic [7:0]        ahr_q,
    output logic [7:0]        aday_q,
    output logic              flag
);
    logic hit;

    // Each field matches when masked or equal; all four must match.
    always_comb begin
        hit = (asec_q[7] || asec_q[6:0] == sec_q[6:0]) &&
              (amin_q[7] || amin_q[6:0] == min_q[6:0]) &&
              (ahr_q[7]  || ahr_q[6:0]  == hr_q[6:0])  &&
              (aday_q[7] || aday_q[2:0] == dow_q[2:0]);
    end

    // Alarm register writes, masked to kept bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asec_q <= 8'h00; amin_q <= 8'h00; ahr_q <= 8'h00; aday_q <= 8'h00;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_ASEC:  asec_q <= wr_data;
                ADR_AMIN:  amin_q <= wr_data;
                ADR_AHOUR: ahr_q  <= wr_data;
                ADR_ADAY:  aday_q <= wr_data & 8'h87;
                default:   ;
            endcase
        end
    end

    // Sticky request flag: set on match, cleared by alarm access.
    always_ff @(posedge clk) begin
        if (!rst_n)            flag <= 1'b0;
        else if (check && hit) flag <= 1'b1;
        else if (clr)          flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_bcd_alarm.sv
// Top of the BCD calendar clock: host decode, control register,
// read mux and interrupt. Assumes one host access per cycle.
module rtc_bcd_alarm
    import rtc_pkg::*;
#(
    parameter int SUB_TICKS = 4,
    localparam int PW       = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic          stop_q, aie_q, sec_done, sec_pulse, sec_step, flag;
    logic          time_wr, restart, alarm_acc, run;
    logic [PW-1:0] phase_q;
    logic [7:0]    sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
    logic [7:0]    asec_q, amin_q, ahr_q, aday_q;

    assign run       = !stop_q;
    assign time_wr   = reg_wr && (reg_addr <= ADR_YEAR);
    assign restart   = reg_wr && (reg_addr == ADR_SEC);
    assign alarm_acc = (reg_wr || reg_rd) && (reg_addr >= ADR_ASEC) && (reg_addr <= ADR_ADAY);
    assign sec_step  = sec_pulse && !time_wr;
    assign irq       = flag && aie_q;

    rtc_prescaler #(.SUB_TICKS(SUB_TICKS), .PW(PW)) i_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
        .restart(restart), .sec_pulse(sec_pulse), .phase(phase_q)
    );

    rtc_timekeeper i_time (
        .clk(clk), .rst_n(rst_n), .step(sec_step), .wr_en(time_wr),
        .wr_addr(reg_addr), .wr_data(reg_wdata),
        .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .dow_q(dow_q),
        .date_q(date_q), .mon_q(mon_q), .yr_q(yr_q)
    );

    rtc_alarm i_alarm (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .clr(alarm_acc), .check(sec_done),
        .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .dow_q(dow_q),
        .asec_q(asec_q), .amin_q(amin_q), .ahr_q(ahr_q), .aday_q(aday_q),
        .flag(flag)
    );

    // Control bits and the one-cycle delayed second marker for the alarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1; aie_q <= 1'b0; sec_done <= 1'b0;
        end else begin
            sec_done <= sec_step;
            if (reg_wr && reg_addr == ADR_CTRL) begin
                stop_q <= reg_wdata[7];
                aie_q  <= reg_wdata[0];
            end
        end
    end

    // Combinational register read mux.
    always_comb begin
        case (reg_addr)
            ADR_SEC:   reg_rdata = sec_q;
            ADR_MIN:   reg_rdata = min_q;
            ADR_HOUR:  reg_rdata = hr_q;
            ADR_DOW:   reg_rdata = dow_q;
            ADR_DATE:  reg_rdata = date_q;
            ADR_MON:   reg_rdata = mon_q;
            ADR_YEAR:  reg_rdata = yr_q;
            ADR_ASEC:  reg_rdata = asec_q;
            ADR_AMIN:  reg_rdata = amin_q;
            ADR_AHOUR: reg_rdata = ahr_q;
            ADR_ADAY:  reg_rdata = aday_q;
            ADR_CTRL:  reg_rdata = {stop_q, 6'b000000, aie_q};
            ADR_STAT:  reg_rdata = {7'b0000000, flag};
            default:   reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_checker.sv
// Temporal checks on the calendar clock, bound into the top module.
module rtc_checker #(
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic          irq,
    input logic          run,
    input logic          sec_step,
    input logic          sec_done,
    input logic          alarm_acc,
    input logic          flag,
    input logic          aie_q,
    input logic [7:0]    sec_q,
    input logic [7:0]    min_q,
    input logic [PW-1:0] phase_q
);
    a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(reg_wr && reg_addr == 4'h0)) |=> $stable(sec_q));

    a_r5_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h0) |=> (phase_q == '0));

    a_r6_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && sec_q == 8'h59) |=> (sec_q == 8'h00));

    a_r6_min_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && sec_q != 8'h59) |=> $stable(min_q));

    a_r12_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_acc && !sec_done) |=> !flag);

    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !alarm_acc) |=> flag);

    a_r13_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !aie_q |-> !irq);
endmodule

bind rtc_bcd_alarm rtc_checker #(.PW(PW)) i_rtc_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .irq(irq), .run(run), .sec_step(sec_step), .sec_done(sec_done),
    .alarm_acc(alarm_acc), .flag(flag), .aie_q(aie_q), .sec_q(sec_q),
    .min_q(min_q), .phase_q(phase_q)
);

// File: tb/test_rtc_bcd_alarm.sv
// Scoreboard bench: driver tasks queue expected values, a monitor
// compares them at the falling edge.
module test_rtc_bcd_alarm;
    localparam int SUB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    typedef struct {
        logic       is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    logic  probe = 1'b0;
    int    n_chk = 0;
    int    n_fail = 0;
    logic  done = 1'b0;

    always #10 clk = ~clk;

    rtc_bcd_alarm #(.SUB_TICKS(SUB)) i_rtc_bcd_alarm (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Monitor: pop one expected item per probed cycle and compare.
    always @(negedge clk) begin
        item_t it;
        logic [7:0] act;
        if (probe) begin
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: empty queue, actual %h expected item", reg_rdata);
            end else begin
                it  = q.pop_front();
                act = it.is_irq ? {7'b0, irq} : reg_rdata;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        reg_rd = 1'b1; reg_addr = a; probe = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0; probe = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
        q.push_back(it);
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(posedge clk); #1;
        end
        tick_en = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic secs(input int n);
        pulses(n * SUB);
    endtask

    task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(4'h2, h); wr(4'h1, m); wr(4'h0, s);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk(4'hB, 8'h80, "R1 control");
        rd_chk(4'h0, 8'h00, "R1 seconds");
        rd_chk(4'h3, 8'h01, "R1 day");
        rd_chk(4'h4, 8'h01, "R1 date");
        rd_chk(4'h5, 8'h01, "R1 month");
        rd_chk(4'hC, 8'h00, "R1 status");
        irq_chk(1'b0, "R1 irq");

        // R4 stopped clock holds
        secs(2);
        rd_chk(4'h0, 8'h00, "R4 stopped");
        wr(4'hB, 8'h00);
        secs(1);
        rd_chk(4'h0, 8'h01, "R4 running");

        // R6 second and minute carry
        set_hms(8'h00, 8'h00, 8'h58);
        secs(1);
        rd_chk(4'h0, 8'h59, "R6 sec step");
        secs(1);
        rd_chk(4'h0, 8'h00, "R6 sec wrap");
        rd_chk(4'h1, 8'h01, "R6 min carry");

        // R5 phase restart
        pulses(2);
        wr(4'h0, 8'h10);
        pulses(SUB - 1);
        rd_chk(4'h0, 8'h10, "R5 partial");
        pulses(1);
        rd_chk(4'h0, 8'h11, "R5 full");

        // R7 R9 year-end cascade
        wr(4'h6, 8'h99); wr(4'h5, 8'h12); wr(4'h4, 8'h31); wr(4'h3, 8'h07);
        set_hms(8'h23, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h2, 8'h00, "R7 hour wrap");
        rd_chk(4'h3, 8'h01, "R9 dow wrap");
        rd_chk(4'h4, 8'h01, "R9 date wrap");
        rd_chk(4'h5, 8'h01, "R9 month wrap");
        rd_chk(4'h6, 8'h00, "R9 year wrap");

        // R8 12-hour transitions
        set_hms(8'h51, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h2, 8'h72, "R8 11AM to 12PM");
        set_hms(8'h72, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h2, 8'h61, "R8 12PM to 1PM");
        wr(4'h4, 8'h05); wr(4'h3, 8'h03);
        set_hms(8'h71, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h2, 8'h52, "R8 11PM to 12AM");
        rd_chk(4'h4, 8'h06, "R8 date carry");
        rd_chk(4'h3, 8'h04, "R8 dow carry");

        // R10 month lengths
        wr(4'h6, 8'h24); wr(4'h5, 8'h02); wr(4'h4, 8'h28);
        set_hms(8'h23, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h4, 8'h29, "R10 leap feb 29");
        set_hms(8'h23, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h4, 8'h01, "R10 leap end date");
        rd_chk(4'h5, 8'h03, "R10 leap end month");
        wr(4'h6, 8'h23); wr(4'h5, 8'h02); wr(4'h4, 8'h28);
        set_hms(8'h23, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h5, 8'h03, "R10 common feb");
        wr(4'h5, 8'h04); wr(4'h4, 8'h30);
        set_hms(8'h23, 8'h59, 8'h59);
        secs(1);
        rd_chk(4'h4, 8'h01, "R10 april 30");
        rd_chk(4'h5, 8'h05, "R10 april month");

        // R11 R12 R13 weekly alarm, enable gating, clear by read
        wr(4'h7, 8'h05); wr(4'h8, 8'h00); wr(4'h9, 8'h00); wr(4'hA, 8'h01);
        wr(4'h3, 8'h01);
        set_hms(8'h00, 8'h00, 8'h04);
        secs(1);
        rd_chk(4'hC, 8'h01, "R11 weekly match");
        irq_chk(1'b0, "R13 irq gated");
        rd_chk(4'hC, 8'h01, "R12 status read keeps flag");
        wr(4'hB, 8'h01);
        irq_chk(1'b1, "R13 irq on");
        rd_chk(4'h7, 8'h05, "R12 alarm read");
        rd_chk(4'hC, 8'h00, "R12 read clears");
        irq_chk(1'b0, "R13 irq off");

        // R11 day mismatch
        wr(4'h3, 8'h02);
        set_hms(8'h00, 8'h00, 8'h04);
        secs(1);
        rd_chk(4'hC, 8'h00, "R11 day mismatch");

        // R11 daily, R12 clear by write
        wr(4'hA, 8'h81);
        rd_chk(4'hA, 8'h81, "R3 alarm day bits");
        set_hms(8'h00, 8'h00, 8'h04);
        secs(1);
        rd_chk(4'hC, 8'h01, "R11 daily");
        wr(4'h8, 8'h00);
        rd_chk(4'hC, 8'h00, "R12 write clears");

        // R11 hourly
        wr(4'h9, 8'h80);
        set_hms(8'h07, 8'h00, 8'h04);
        secs(1);
        rd_chk(4'hC, 8'h01, "R11 hourly");
        rd_chk(4'h9, 8'h80, "R12 clear hourly");
        set_hms(8'h07, 8'h33, 8'h04);
        secs(1);
        rd_chk(4'hC, 8'h00, "R11 hourly minute miss");

        // R11 per-minute and per-second
        wr(4'h8, 8'h80);
        set_hms(8'h07, 8'h33, 8'h04);
        secs(1);
        rd_chk(4'hC, 8'h01, "R11 per minute");
        wr(4'h7, 8'h80);
        set_hms(8'h07, 8'h33, 8'h20);
        secs(1);
        rd_chk(4'hC, 8'h01, "R11 per second");

        // R13 disabling enable drops irq, flag stays
        wr(4'hB, 8'h00);
        irq_chk(1'b0, "R13 enable off");
        rd_chk(4'hC, 8'h01, "R13 flag kept");

        // R3 and R2 unused bits and empty addresses
        wr(4'h3, 8'hFF);
        rd_chk(4'h3, 8'h07, "R3 dow mask");
        wr(4'h0, 8'hFF);
        rd_chk(4'h0, 8'h7F, "R3 seconds mask");
        wr(4'hB, 8'hFF);
        rd_chk(4'hB, 8'h81, "R3 control mask");
        wr(4'hD, 8'hFF);
        rd_chk(4'hD, 8'h00, "R2 empty address");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule